// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register load or store request into a stream of single-word transfers. A request carries a register mask with one bit per architectural register, the current value of the base register and its index, and four mode bits: pre/post, up/down, writeback and load/store. From the number of set bits the block works out the first address, the address after the last transfer and the value the base register takes on writeback. It then issues one transfer per accepted cycle, naming the register, the byte address and the direction.

A register-file port and a memory port sit beside the sequencer. On a store, the block chooses the word to write from the register-file read data or from the captured base value. On a load, it conditions the memory word before it goes back to the register file. When the last transfer has been accepted, the block reports the written-back base value and a flag for operand combinations whose outcome is undefined. The integration this block expects applies the writeback to the register file as soon as the request is accepted. For that reason a store of the base register reads the captured original value, not the register file.

Top module: `blkxfer_seq`

## Requirements
- R1: Each set bit i of `start_list` produces exactly one transfer with `xfer_reg` = i, so the number of transfers equals the number of set bits.
- R2: Transfers come out in ascending register index. Each accepted transfer that is followed by another adds 4 to `xfer_addr`.
- R3: The first address depends on {`start_pre`,`start_up`}. For 01 (increment-after) it is base. For 11 (increment-before) it is base+4. For 00 (decrement-after) it is base−4·n+4. For 10 (decrement-before) it is base−4·n. Here n is the set-bit count.
- R4: `done_base` is base+4·n when `start_wb`=1 and `start_up`=1, base−4·n when `start_wb`=1 and `start_up`=0, and the unchanged base when `start_wb`=0.
- R5: On a load transfer to register 15, `rf_wdata` is `mem_rdata` with bits [1:0] forced to 0. Other registers receive `mem_rdata` unchanged.
- R6: On a store with writeback where the base register is the lowest set bit, that transfer's `xfer_wdata` is the captured `start_base`. All other store transfers drive `rf_rdata`.
- R7: A store with writeback whose list holds the base register at a position other than the lowest sets `done_unpred`.
- R8: A load with writeback whose list holds the base register sets `done_unpred`. Requests outside R7, R8 and R9 leave `done_unpred` at 0.
- R9: An empty list issues no transfer. It raises `done_valid` with `done_unpred`=1 on the cycle after acceptance.
- R10: `start_ready` is high only when the block is idle. While `xfer_valid` is high and `xfer_ready` is low, register, address and direction hold steady.
- R11: The last transfer address equals the first address plus 4·(n−1). `done_valid` rises on the cycle after the last transfer is accepted and lasts one cycle.
- R12: `xfer_load` equals the `start_load` of the request on every transfer. It is 1 for load and 0 for store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Block idle, request accepted this cycle if valid |
| start_list | input | 16 | Register mask, bit i selects register i |
| start_base | input | 32 | Base register value |
| start_base_idx | input | 4 | Index of the base register |
| start_pre | input | 1 | 1: address stepped before the first access |
| start_up | input | 1 | 1: addresses ascend from base |
| start_wb | input | 1 | 1: base register is updated |
| start_load | input | 1 | 1: load, 0: store |
| xfer_valid | output | 1 | Transfer present |
| xfer_ready | input | 1 | Transfer taken this cycle |
| xfer_reg | output | 4 | Register index of the transfer |
| xfer_addr | output | 32 | Byte address of the transfer |
| xfer_load | output | 1 | Direction of the transfer |
| rf_rdata | input | 32 | Register-file read data for `xfer_reg` |
| xfer_wdata | output | 32 | Store data toward memory |
| mem_rdata | input | 32 | Memory read data at `xfer_addr` |
| rf_wdata | output | 32 | Load data toward the register file |
| done_valid | output | 1 | One-cycle completion pulse |
| done_base | output | 32 | Final base register value |
| done_unpred | output | 1 | Undefined operand combination or empty list |

## Verification
A wrong remaining-mask bit shows up at the very next accepted transfer as a skipped, repeated or out-of-order register index, or as a missing completion pulse. An error in the count or mode decode is visible on the first transfer of the request, because the first address is off, and again at completion, because the reported base value is wrong. A broken first-transfer marker only affects the stored word in the base-lowest writeback case, so directed stores of the base register as the lowest bit go alongside random mixes of masks, modes and stall patterns.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  // Addressing mode, encoded as {pre, up}
  typedef enum logic [1:0] {
    AM_DEC_AFTER  = 2'b00,
    AM_INC_AFTER  = 2'b01,
    AM_DEC_BEFORE = 2'b10,
    AM_INC_BEFORE = 2'b11
  } addr_mode_t;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // Ripple adder chain, one stage per mask bit
  logic [CW-1:0] partial [N+1];
  assign partial[0] = '0;
  for (genvar g = 0; g < N; g++) begin : g_stage
    assign partial[g+1] = partial[g] + CW'(vec[g]);
  end
  assign cnt = partial[N];
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/blkxfer_plan.sv
module blkxfer_plan
  import blkxfer_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1),
  localparam int BSH = $clog2(WORD_BYTES)
) (
  input  logic [NREG-1:0] list,
  input  logic [AW-1:0]   base,
  input  logic [IW-1:0]   base_idx,
  input  logic            pre,
  input  logic            up,
  input  logic            wb,
  input  logic            load,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   wb_value,
  output logic [IW-1:0]   low_idx,
  output logic            any,
  output logic            unpred
);
  logic [CW-1:0] cnt;
  logic [AW-1:0] span;
  addr_mode_t    mode;

  blkxfer_popcnt #(.N(NREG)) u_cnt (.vec(list), .cnt(cnt));
  blkxfer_lowbit #(.N(NREG)) u_low (.vec(list), .idx(low_idx), .any(any));

  assign span = AW'(cnt) << BSH;
  assign mode = addr_mode_t'({pre, up});

  always_comb begin
    unique case (mode)
      AM_INC_AFTER:  first_addr = base;
      AM_INC_BEFORE: first_addr = base + AW'(WORD_BYTES);
      AM_DEC_AFTER:  first_addr = base - span + AW'(WORD_BYTES);
      default:       first_addr = base - span;
    endcase
  end

  assign wb_value = up ? (base + span) : (base - span);

  // Base in list under writeback: defined only for a store with base lowest
  assign unpred = !any ||
                  (wb && list[base_idx] && (load || (low_idx != base_idx)));
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_valid,
  output logic            start_ready,
  input  logic [NREG-1:0] start_list,
  input  logic [AW-1:0]   start_base,
  input  logic [IW-1:0]   start_base_idx,
  input  logic            start_pre,
  input  logic            start_up,
  input  logic            start_wb,
  input  logic            start_load,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [IW-1:0]   xfer_reg,
  output logic [AW-1:0]   xfer_addr,
  output logic            xfer_load,
  input  logic [AW-1:0]   rf_rdata,
  output logic [AW-1:0]   xfer_wdata,
  input  logic [AW-1:0]   mem_rdata,
  output logic [AW-1:0]   rf_wdata,
  output logic            done_valid,
  output logic [AW-1:0]   done_base,
  output logic            done_unpred
);
  localparam logic [IW-1:0] PC_IDX   = IW'(NREG - 1);
  localparam logic [AW-1:0] LOW_MASK = AW'(WORD_BYTES - 1);

  seq_state_t      state;
  logic [NREG-1:0] rem_q;
  logic [IW-1:0]   reg_q;
  logic [AW-1:0]   addr_q;
  logic            first_q;
  logic            load_q;
  logic            wb_q;
  logic [AW-1:0]   orig_base_q;
  logic [IW-1:0]   base_idx_q;
  logic [AW-1:0]   done_base_q;
  logic            unpred_q;

  logic [AW-1:0]   plan_first;
  logic [AW-1:0]   plan_wb;
  logic [IW-1:0]   plan_low;
  logic            plan_any;
  logic            plan_unpred;

  logic [NREG-1:0] rem_next;
  logic [IW-1:0]   next_idx;
  logic            next_any;

  blkxfer_plan #(
    .NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)
  ) u_plan (
    .list(start_list), .base(start_base), .base_idx(start_base_idx),
    .pre(start_pre), .up(start_up), .wb(start_wb), .load(start_load),
    .first_addr(plan_first), .wb_value(plan_wb), .low_idx(plan_low),
    .any(plan_any), .unpred(plan_unpred)
  );

  assign rem_next = rem_q & ~(NREG'(1) << reg_q);

  blkxfer_lowbit #(.N(NREG)) u_next (.vec(rem_next), .idx(next_idx), .any(next_any));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rem_q       <= '0;
      reg_q       <= '0;
      addr_q      <= '0;
      first_q     <= 1'b0;
      load_q      <= 1'b0;
      wb_q        <= 1'b0;
      orig_base_q <= '0;
      base_idx_q  <= '0;
      done_base_q <= '0;
      unpred_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_valid) begin
            rem_q       <= start_list;
            reg_q       <= plan_low;
            addr_q      <= plan_first;
            first_q     <= 1'b1;
            load_q      <= start_load;
            wb_q        <= start_wb;
            orig_base_q <= start_base;
            base_idx_q  <= start_base_idx;
            done_base_q <= start_wb ? plan_wb : start_base;
            unpred_q    <= plan_unpred;
            state       <= plan_any ? ST_XFER : ST_FIN;
          end
        end
        ST_XFER: begin
          if (xfer_ready) begin
            rem_q   <= rem_next;
            reg_q   <= next_idx;
            addr_q  <= addr_q + AW'(WORD_BYTES);
            first_q <= 1'b0;
            if (!next_any) state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign start_ready = (state == ST_IDLE);
  assign xfer_valid  = (state == ST_XFER);
  assign done_valid  = (state == ST_FIN);
  assign xfer_reg    = reg_q;
  assign xfer_addr   = addr_q;
  assign xfer_load   = load_q;
  assign done_base   = done_base_q;
  assign done_unpred = unpred_q;

  // Base stored as lowest register under writeback: original value
  assign xfer_wdata = (!load_q && wb_q && first_q && (reg_q == base_idx_q))
                      ? orig_base_q : rf_rdata;

  // Program-counter load: drop the sub-word address bits
  assign rf_wdata = (reg_q == PC_IDX) ? (mem_rdata & ~LOW_MASK) : mem_rdata;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            start_valid,
  input logic            start_ready,
  input logic [NREG-1:0] start_list,
  input logic            xfer_valid,
  input logic            xfer_ready,
  input logic [IW-1:0]   xfer_reg,
  input logic [AW-1:0]   xfer_addr,
  input logic            xfer_load,
  input logic [AW-1:0]   rf_wdata,
  input logic            done_valid,
  input logic            done_unpred
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) &&
                                  $stable(xfer_reg) && $stable(xfer_load)); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_valid && xfer_ready) && xfer_valid |->
      xfer_addr == $past(xfer_addr) + AW'(WORD_BYTES)); // R2

  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_valid && xfer_ready) && xfer_valid |-> xfer_reg > $past(xfer_reg)); // R2

  AST_PC_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && xfer_load && xfer_reg == IW'(NREG - 1) |->
      (rf_wdata & AW'(WORD_BYTES - 1)) == '0); // R5

  AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (rst)
    start_valid && start_ready && start_list == '0 |=>
      done_valid && done_unpred && !xfer_valid); // R9

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_ready && (xfer_valid || done_valid))); // R10

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_valid) |-> done_valid); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R11
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/blkxfer_seq_test.sv
`timescale 1ns/1ps
module blkxfer_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] start_list = '0;
  logic [31:0] start_base = '0;
  logic [3:0]  start_base_idx = '0;
  logic        start_pre = 1'b0, start_up = 1'b0, start_wb = 1'b0, start_load = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr;
  logic        xfer_load;
  logic [31:0] rf_rdata, xfer_wdata, mem_rdata, rf_wdata;
  logic        done_valid;
  logic [31:0] done_base;
  logic        done_unpred;

  logic [31:0] regs [16];
  logic [31:0] mem  [512];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign rf_rdata  = regs[xfer_reg];
  assign mem_rdata = mem[xfer_addr[10:2]];

  blkxfer_seq uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_start(input logic [31:0] b, input int n, input logic p, input logic u);
    case ({p, u})
      2'b01:   return b;
      2'b11:   return b + 32'd4;
      2'b00:   return b - 32'(4 * n) + 32'd4;
      default: return b - 32'(4 * n);
    endcase
  endfunction

  task automatic run_op(input logic [15:0] lst, input int bidx, input logic p, input logic u,
                        input logic w, input logic l);
    logic [31:0] base, start, wbv, eaddr, last_addr, ed;
    int n, low;
    bit unp, rdy;
    base = regs[bidx];
    n = 0; low = -1;
    for (int i = 15; i >= 0; i--) if (lst[i]) begin n++; low = i; end
    start = exp_start(base, n, p, u);
    wbv   = u ? base + 32'(4 * n) : base - 32'(4 * n);
    unp   = (n == 0) || (w && lst[bidx] && (l || low != bidx));
    @(negedge clk);
    chk(start_ready, "R10 idle ready", 32'(start_ready), 32'd1);
    start_list = lst; start_base = base; start_base_idx = 4'(bidx);
    start_pre = p; start_up = u; start_wb = w; start_load = l; start_valid = 1'b1;
    @(posedge clk);
    if (w) regs[bidx] = wbv;
    @(negedge clk);
    start_valid = 1'b0;
    eaddr = start; last_addr = start;
    for (int r = 0; r < 16; r++) begin
      if (lst[r]) begin
        do begin
          rdy = ($urandom % 4) != 0;
          xfer_ready = rdy;
          #0.1;
          chk(xfer_valid, "R1 transfer valid", 32'(xfer_valid), 32'd1);
          chk(xfer_reg == 4'(r), "R1/R2 register order", 32'(xfer_reg), 32'(r));
          chk(xfer_addr == eaddr, (eaddr == start) ? "R3 first address" : "R2 address step",
              xfer_addr, eaddr);
          chk(xfer_load == l, "R12 direction", 32'(xfer_load), 32'(l));
          if (rdy) begin
            if (l) begin
              ed = mem[eaddr[10:2]];
              if (r == 15) ed = ed & ~32'd3;
              chk(rf_wdata == ed, (r == 15) ? "R5 pc load mask" : "R5 load data", rf_wdata, ed);
              regs[r] = rf_wdata;
            end else begin
              ed = (w && r == bidx && r == low) ? base : regs[r];
              chk(xfer_wdata == ed, (w && r == bidx) ? "R6 base store value" : "R6 store data",
                  xfer_wdata, ed);
              mem[eaddr[10:2]] = xfer_wdata;
            end
            last_addr = eaddr;
          end
          @(posedge clk);
          @(negedge clk);
        end while (!rdy);
        eaddr = eaddr + 32'd4;
      end
    end
    xfer_ready = 1'b0;
    #0.1;
    chk(done_valid && !xfer_valid, (n == 0) ? "R9 empty completes" : "R11 done after last",
        {30'd0, xfer_valid, done_valid}, 32'd1);
    chk(done_base == (w ? wbv : base), "R4 final base", done_base, w ? wbv : base);
    chk(done_unpred == unp, (n == 0) ? "R9 empty flag" : (l ? "R8 unpredictable flag" : "R7 unpredictable flag"),
        32'(done_unpred), 32'(unp));
    if (n > 0)
      chk(last_addr == start + 32'(4 * (n - 1)), "R11 final address", last_addr, start + 32'(4 * (n - 1)));
    @(posedge clk);
    @(negedge clk);
    chk(start_ready && !done_valid, "R11 single done pulse", {30'd0, done_valid, start_ready}, 32'd1);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    for (int i = 0; i < 512; i++) mem[i] = $urandom;
    repeat (3) @(posedge clk);
    #0.1;
    chk(!xfer_valid && !done_valid, "R10 reset outputs", {30'd0, done_valid, xfer_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      regs[13] = 32'h2000_0400;
      run_op(16'h0000, 13, m[1], m[0], 1'b1, 1'b0);       // R9 empty list
      run_op(16'hFFFF, 13, m[1], m[0], 1'b0, 1'b0);       // R3 full list store
      run_op(16'h0200, 13, m[1], m[0], 1'b1, 1'b1);       // R3 single register
    end
    regs[2] = 32'h2000_0300;
    mem[32'h2000_0300 >> 2 & 511] = 32'hDEAD_BEEF;
    run_op(16'h8000, 2, 1'b0, 1'b1, 1'b0, 1'b1);           // R5 load into pc
    regs[4] = 32'h2000_0500;
    run_op(16'h0C10, 4, 1'b1, 1'b0, 1'b1, 1'b0);           // R6 base lowest, writeback
    regs[4] = 32'h2000_0500;
    run_op(16'h0C13, 4, 1'b0, 1'b1, 1'b1, 1'b0);           // R7 base not lowest
    regs[4] = 32'h2000_0500;
    run_op(16'h0C10, 4, 1'b0, 1'b1, 1'b1, 1'b1);           // R8 load base with writeback
    regs[4] = 32'h2000_0500;
    run_op(16'h0C10, 4, 1'b0, 1'b1, 1'b0, 1'b1);           // R8 no writeback: defined
    for (int k = 0; k < 300; k++) begin
      int b;
      logic [15:0] lst;
      b = $urandom % 16;
      lst = 16'($urandom);
      if (k % 3 == 0) lst = lst & 16'($urandom);
      regs[b] = 32'h4000_0000 | ((32'd64 + ($urandom % 384)) << 2);
      run_op(lst, b, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule